// File: doc/BRIEF.md
# Single-Wire Bus Slave Identity Command Responder

This block is the digital part of a single-wire bus slave that runs once the bus has been reset and the slave has answered with its presence pulse. A slot-level front end turns the line waveform into three event strobes: a written bit with its value, a request for the slave's bit in a read slot, and detection of a long low (bus reset). The responder gathers an 8-bit identity-level command from the written bits, least significant bit first. It then runs that command against a 64-bit device identity supplied on an input port. The identity's low byte is the family code, the middle 48 bits are the serial number, and the top byte is the check byte.

Five commands are handled: read identity, match identity, skip, search and alarm-conditioned search. In a search the slave joins the wired-AND bit-by-bit elimination and drops out when the master selects the other branch. The alarm-conditioned search runs only while the alarm flag input is set. When a command completes successfully, the `selected` output unlocks the memory command layer until the next bus reset. The `txBit` output is the value the front end places on the line in each read slot, and a 1 means the line is released.

Top module: `ow_rom_responder`

## Requirements
- R1: After a bus reset, the first 8 written bits form the command, least significant bit first. Written bits and read requests seen before the first bus reset after power-up have no effect: `txBit` stays 1 and `selected` stays 0.
- R2: Command CCh (skip) sets `selected` in the cycle after its eighth bit is registered, and no identity bits are exchanged.
- R3: After command 33h (read identity), `txBit` presents identity bit k (k = 0 first, bit 0 being the LSB of the family code in `idCode[7:0]`). Each read request moves on to bit k+1. The read request that consumes bit ID_W-1 sets `selected`.
- R4: After command 55h (match identity), the next ID_W written bits are compared with identity bits 0 upward. If all of them agree, `selected` is set after the last one. On the first disagreement the slave ignores all traffic until a bus reset: `selected` stays 0 and `txBit` stays 1.
- R5: After command F0h (search), for each identity bit k the slave answers the first read request with bit k and the second with its complement. It then takes the master's written bit. If that bit equals bit k the slave continues, otherwise it drops out as in R4. Completing all ID_W bits sets `selected`.
- R6: Command ECh (alarm search) behaves as R5 when `alarmFlag` is 1 as its eighth bit is registered. Otherwise the slave does not take part: `txBit` stays 1 and `selected` stays 0 until a bus reset.
- R7: A bus reset in any state clears `selected` and restarts command reception at bit 0.
- R8: Any other command code leaves the slave idle until a bus reset, with `txBit` 1 and `selected` 0.
- R9: `txBit` is 1 whenever the slave has no bit of its own to send. Once set, `selected` holds until a bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReset | input | 1 | Strobe: long low detected on the line |
| bitValid | input | 1 | Strobe: the master wrote a bit |
| bitData | input | 1 | Value of the written bit, valid with `bitValid` |
| readReq | input | 1 | Strobe: a read slot has been taken by the master |
| alarmFlag | input | 1 | Alarm condition from the last measurement |
| idCode | input | ID_W | Device identity; family code in bits 7:0 |
| txBit | output | 1 | Bit to place on the line in read slots (1 = released) |
| selected | output | 1 | Identity stage completed; memory commands allowed |

## Verification
The bench builds the responder with ID_W = 16, so a full identity exchange takes a few dozen events. This makes it cheap to sweep all 256 command codes with the alarm flag both set and clear, and to exercise every known command to completion on each pass. With the short identity, a mismatch in match and a drop-out in search can be forced at every bit position, for two identities of different bit patterns. It also leaves room to test bus resets in the middle of a stream and traffic before the first bus reset.

// File: rtl/ow_rom_pkg.sv
package ow_rom_pkg;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_READ   = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH  = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SKIP   = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_SEARCH = 8'hF0;
  localparam logic [CMD_W-1:0] CMD_ALARM  = 8'hEC;

  typedef enum logic [3:0] {
    S_IDLE,   // waiting for first bus reset
    S_CMD,    // gathering command bits
    S_READ,   // streaming identity
    S_MATCH,  // comparing written bits
    S_ST,     // search: send true bit
    S_SC,     // search: send complement
    S_SW,     // search: take master's choice
    S_SEL,    // identity stage done
    S_DEAD    // out until bus reset
  } respState_t;

  typedef struct packed {
    logic cmdShift;
    logic idxClr;
    logic idxInc;
  } dpStrobe_t;

endpackage

// File: rtl/ow_rom_datapath.sv
module ow_rom_datapath
  import ow_rom_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              stb,
  input  logic                   bitData,
  input  logic [ID_W-1:0]        idCode,
  output logic [CMD_W-1:0]       nextCmd,
  output logic                   curBit,
  output logic                   cmdFull,
  output logic                   idxLast
);

  localparam int IDX_W = $clog2(ID_W);

  logic [CMD_W-1:0] cmdReg;
  logic [IDX_W-1:0] bitIdx;

  // LSB arrives first, so each new bit enters at the top
  assign nextCmd = {bitData, cmdReg[CMD_W-1:1]};
  assign curBit  = idCode[bitIdx];
  assign cmdFull = (bitIdx == IDX_W'(CMD_W-1));
  assign idxLast = (bitIdx == IDX_W'(ID_W-1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
      bitIdx <= '0;
    end else begin
      if (stb.cmdShift) cmdReg <= nextCmd;
      if (stb.idxClr)      bitIdx <= '0;
      else if (stb.idxInc) bitIdx <= bitIdx + 1'b1;
    end
  end

  // R3/R4/R5: control must never step the index beyond the identity
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (stb.idxInc && !stb.idxClr) |-> !idxLast);

endmodule

// File: rtl/ow_rom_ctrl.sv
module ow_rom_ctrl
  import ow_rom_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busReset,
  input  logic             bitValid,
  input  logic             bitData,
  input  logic             readReq,
  input  logic             alarmFlag,
  input  logic [CMD_W-1:0] nextCmd,
  input  logic             curBit,
  input  logic             cmdFull,
  input  logic             idxLast,
  output dpStrobe_t        stb,
  output logic             txBit,
  output logic             selected
);

  respState_t state, nState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nState;
  end

  always_comb begin
    nState = state;
    stb    = '0;
    if (busReset) begin
      nState     = S_CMD;
      stb.idxClr = 1'b1;
    end else begin
      unique case (state)
        S_CMD: if (bitValid) begin
          stb.cmdShift = 1'b1;
          if (cmdFull) begin
            stb.idxClr = 1'b1;
            unique case (nextCmd)
              CMD_READ:   nState = S_READ;
              CMD_MATCH:  nState = S_MATCH;
              CMD_SKIP:   nState = S_SEL;
              CMD_SEARCH: nState = S_ST;
              CMD_ALARM:  nState = alarmFlag ? S_ST : S_DEAD;
              default:    nState = S_DEAD;
            endcase
          end else begin
            stb.idxInc = 1'b1;
          end
        end
        S_READ: if (readReq) begin
          if (idxLast) nState = S_SEL;
          else         stb.idxInc = 1'b1;
        end
        S_MATCH: if (bitValid) begin
          if (bitData != curBit) nState = S_DEAD;
          else if (idxLast)      nState = S_SEL;
          else                   stb.idxInc = 1'b1;
        end
        S_ST: if (readReq) nState = S_SC;
        S_SC: if (readReq) nState = S_SW;
        S_SW: if (bitValid) begin
          if (bitData != curBit) nState = S_DEAD;
          else if (idxLast)      nState = S_SEL;
          else begin
            stb.idxInc = 1'b1;
            nState     = S_ST;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      S_READ, S_ST: txBit = curBit;
      S_SC:         txBit = ~curBit;
      default:      txBit = 1'b1;
    endcase
  end

  assign selected = (state == S_SEL);

  a_r2_skip_selects: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_CMD && bitValid && !busReset && cmdFull && nextCmd == CMD_SKIP)
    |=> selected);

  a_r5_complement: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ST && readReq && !busReset) |=> (txBit == !$past(txBit)));

  a_r7_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> !selected);

  a_r9_sel_holds: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !busReset) |=> selected);

  a_r4_mismatch_drops: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_MATCH && bitValid && !busReset && bitData != curBit)
    |=> (!selected && txBit));

endmodule

// File: rtl/ow_rom_responder.sv
module ow_rom_responder
  import ow_rom_pkg::*;
#(
  parameter int ID_W = 64
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            busReset,
  input  logic            bitValid,
  input  logic            bitData,
  input  logic            readReq,
  input  logic            alarmFlag,
  input  logic [ID_W-1:0] idCode,
  output logic            txBit,
  output logic            selected
);

  dpStrobe_t        stb;
  logic [CMD_W-1:0] nextCmd;
  logic             curBit;
  logic             cmdFull;
  logic             idxLast;

  ow_rom_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busReset(busReset), .bitValid(bitValid),
    .bitData(bitData), .readReq(readReq), .alarmFlag(alarmFlag),
    .nextCmd(nextCmd), .curBit(curBit), .cmdFull(cmdFull),
    .idxLast(idxLast), .stb(stb), .txBit(txBit), .selected(selected)
  );

  ow_rom_datapath #(.ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .bitData(bitData), .idCode(idCode),
    .nextCmd(nextCmd), .curBit(curBit), .cmdFull(cmdFull), .idxLast(idxLast)
  );

endmodule

// File: tb/sim_ow_rom_responder.sv
module sim_ow_rom_responder;

  localparam int ID_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busReset = 1'b0, bitValid = 1'b0, bitData = 1'b0, readReq = 1'b0;
  logic alarmFlag = 1'b0;
  logic [ID_W-1:0] idCode = 16'hA53C;
  logic txBit, selected;

  int nChk = 0, nBad = 0, cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  ow_rom_responder #(.ID_W(ID_W)) u0 (
    .clk(clk), .rstN(rstN), .busReset(busReset), .bitValid(bitValid),
    .bitData(bitData), .readReq(readReq), .alarmFlag(alarmFlag),
    .idCode(idCode), .txBit(txBit), .selected(selected)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %b expected %b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wrBit(input logic b);
    @(negedge clk); bitValid = 1'b1; bitData = b;
    @(negedge clk); bitValid = 1'b0;
  endtask

  task automatic rdSlot();
    @(negedge clk); readReq = 1'b1;
    @(negedge clk); readReq = 1'b0;
  endtask

  task automatic busRst();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

  task automatic sendCmd(input logic [7:0] c);
    for (int i = 0; i < 8; i++) wrBit(c[i]);
  endtask

  // full read identity, checking each bit (R3)
  task automatic doRead();
    for (int i = 0; i < ID_W; i++) begin
      chk("R3 read bit", txBit, idCode[i]);
      if (i == ID_W-1) chk("R3 not early", selected, 1'b0);
      rdSlot();
    end
    chk("R3 selected after last read", selected, 1'b1);
  endtask

  // search; drop at position dropAt (ID_W = no drop)
  task automatic doSearch(input int dropAt, input string req);
    for (int i = 0; i < ID_W; i++) begin
      if (i > dropAt) begin
        chk({req, " dropped txBit"}, txBit, 1'b1);
        rdSlot(); rdSlot(); wrBit(idCode[i]);
      end else begin
        chk({req, " true bit"}, txBit, idCode[i]);
        rdSlot();
        chk({req, " complement"}, txBit, ~idCode[i]);
        rdSlot();
        chk({req, " released during write"}, txBit, 1'b1);
        wrBit(i == dropAt ? ~idCode[i] : idCode[i]);
      end
    end
    chk({req, " selected"}, selected, dropAt >= ID_W);
    chk({req, " txBit idle"}, txBit, 1'b1);
  endtask

  task automatic doMatch(input int badAt);
    for (int i = 0; i < ID_W; i++) begin
      wrBit(i == badAt ? ~idCode[i] : idCode[i]);
      if (i >= badAt) chk("R4 txBit after mismatch", txBit, 1'b1);
    end
    chk("R4 match result", selected, badAt >= ID_W);
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 200000 && !finished) begin
        nChk++; nBad++;
        $display("FAIL watchdog: actual %0d cycles expected < 200000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset selected", selected, 1'b0);
    chk("R9 reset txBit", txBit, 1'b1);
    rstN = 1'b1;

    // R1: traffic before first bus reset is ignored
    sendCmd(8'hCC);
    chk("R1 skip before bus reset ignored", selected, 1'b0);
    for (int i = 0; i < 4; i++) begin rdSlot(); chk("R1 txBit pre-reset", txBit, 1'b1); end

    // sweep every command code with alarm flag both ways
    for (int a = 0; a < 2; a++) begin
      alarmFlag = a[0];
      for (int c = 0; c < 256; c++) begin
        busRst();
        chk("R7 cleared by bus reset", selected, 1'b0);
        sendCmd(8'(c));
        if (c == 8'hCC) begin
          chk("R2 skip selects", selected, 1'b1);
          chk("R9 txBit idle when selected", txBit, 1'b1);
          wrBit(1'b0); rdSlot();
          chk("R9 selected holds", selected, 1'b1);
        end else if (c == 8'h33) begin
          doRead();
        end else if (c == 8'h55) begin
          doMatch(ID_W);
        end else if (c == 8'hF0) begin
          doSearch(ID_W, "R5 search");
        end else if (c == 8'hEC && a == 1) begin
          doSearch(ID_W, "R6 alarm search");
        end else begin
          for (int i = 0; i < ID_W; i++) begin
            rdSlot();
            chk(c == 8'hEC ? "R6 no alarm txBit" : "R8 unknown txBit", txBit, 1'b1);
            wrBit(idCode[i]);
          end
          chk(c == 8'hEC ? "R6 no alarm not selected" : "R8 unknown not selected",
              selected, 1'b0);
        end
      end
    end

    // mismatch / drop-out at every position, two identities
    for (int v = 0; v < 2; v++) begin
      idCode = (v == 0) ? 16'hA53C : 16'h0F71;
      alarmFlag = 1'b1;
      for (int p = 0; p < ID_W; p++) begin
        busRst(); sendCmd(8'h55); doMatch(p);
        busRst(); sendCmd(8'hF0); doSearch(p, "R5 drop");
        busRst(); sendCmd(8'hEC); doSearch(p, "R6 drop");
      end
      busRst(); sendCmd(8'h33); doRead();
    end

    // R7: bus reset mid-stream restarts command reception
    busRst(); sendCmd(8'h33);
    rdSlot(); rdSlot();
    busRst();
    chk("R7 txBit after mid-read reset", txBit, 1'b1);
    sendCmd(8'hCC);
    chk("R7 new command after reset", selected, 1'b1);
    busRst(); wrBit(1'b0); wrBit(1'b0); wrBit(1'b1);
    busRst(); sendCmd(8'hCC);
    chk("R7 partial command discarded", selected, 1'b1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule